// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the target side of a four-wire serial control port that configures a mixed-signal upconversion front end. The host frames every access as 24 clocks with chip select held low. The first seven bits choose read or write and name a register. The next sixteen bits carry the data word. The last bit is an optional parity bit. The block runs on its own system clock. It oversamples the serial clock, select and data lines through two-flop synchronizers and recovers their edges. The host's serial clock must therefore have a half period of at least four system clocks.

Writes update a small register file. Its fields drive the analog control outputs: block enables, linearizer code, LO sideband and I/Q phase trims, and detector output select. A read returns the addressed register in the data bits of the same frame. Frames with a wrong clock count, a bad parity bit or an unknown address are caught and recorded in sticky alarm bits. A small converter model stands in for the detector ADC. When it is started, enabled and clocked, it reports ready after a set latency and captures its result from a test input.

The frame shifter is a state machine. FE_IDLE goes to FE_HEAD when select falls. FE_HEAD goes to FE_BODY on the seventh serial clock rise. FE_BODY goes to FE_OVER on a rise after 24 bits have been taken. Any of FE_HEAD, FE_BODY or FE_OVER returns to FE_IDLE when select rises. The converter model is a second state machine. CV_OFF goes to CV_BUSY when all three converter control bits are 1. CV_BUSY goes to CV_READY after the latency count. CV_BUSY or CV_READY falls back to CV_OFF when any of the three bits drops.

Top module: `cfgspi_slave`

## Requirements
- R1: A frame is 24 bits sent MSB first and sampled on rising serial clock edges. Bit 23 = 1 means read. Bits 22:17 are the register address and bits 16:1 are the data word. A complete write updates the addressed register.
- R2: On a read, the target drives the register value on the data output in frame bits 16:1 of the same frame. The output changes after falling serial clock edges. It is 0 in all other bit times and whenever the port is idle.
- R3: Register 0x00 reads bit 15 = parity enable, bit 14 = soft reset, bits 13:12 = 0, bits 11:4 = fixed identity 0x0A and bits 3:0 = revision parameter (default 0x1). Its reset value reads 0x00A1.
- R4: Register 0x03 holds nine enable bits at 8:0, which appear on `en_ctl`. Bits 15:9 are dropped on write and read as 0. Writing 0 clears every enable.
- R5: Register 0x05 holds a sideband select (bit 10), a Q trim (bits 7:4) and an I trim (bits 3:0). Register 0x04 holds the linearizer code in bits 7:0. All of these drive their matching outputs, and unused bits read 0.
- R6: Register 0x06 bits 3:0 are detector select, start, converter enable and converter clock enable. When start, enable and clock enable are all 1, ready (bit 8 of register 0x0C) rises ADC_LAT to ADC_LAT+2 system clocks later. At that moment `adc_sample` is captured into bits 7:0. Ready falls when any of the three bits is cleared, and the captured value is kept.
- R7: A frame that ends with fewer than 24 rising clocks, including zero clocks, changes no register. It sets alarm bit 14 of register 0x01.
- R8: A frame that ends with more than 24 rising clocks changes no register. It sets alarm bit 13 of register 0x01.
- R9: A complete frame whose address is not one of 0x00–0x06 or 0x0C sets alarm bit 12. Such a read returns 0, and such a write has no effect.
- R10: While parity is enabled, frame bit 0 must make the count of ones over all 24 bits odd. A frame that fails this sets alarm bit 15 and performs no write. Read data is still returned.
- R11: Alarm bits are sticky and accumulate. A complete read of register 0x01 returns the alarms then set and clears them at the end of that frame.
- R12: A write to register 0x00 with bit 14 = 1 returns every writable field to 0, parity enable included. Bit 14 then reads 1 until a write to 0x00 with bit 14 = 0.
- R13: Writes to the read-only registers 0x01 and 0x0C have no effect and raise no alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| adc_sample | input | 8 | Test value captured by the converter model |
| en_ctl | output | 9 | Block enable word |
| lin_code | output | 8 | Linearizer code |
| lo_sb_sel | output | 1 | LO sideband select |
| i_trim | output | 4 | I path phase trim |
| q_trim | output | 4 | Q path phase trim |
| det_out_sel | output | 1 | Detector output select |

## Verification
Register traffic uses several data patterns: alternating bits, all ones and all zeros. These show that each field lands in its own bits and that unused bits are dropped rather than stored. Broken frames (zero, 20 and 28 clocks) and accesses to unknown and read-only addresses check that a rejected frame leaves the outputs alone and raises only its own alarm bit. Back-to-back faults check that alarms accumulate. Parity is tested with good and bad frames for both writes and reads, which separates write suppression from data return. The converter is read before and after its latency, and again after the test input changes and after start is dropped. This separates the ready timing from the moment the value is captured.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;
    localparam int FRAME_BITS = 24;
    localparam int HEAD_BITS  = 7;
    localparam int WORD_BITS  = 16;
    localparam int ADDR_BITS  = HEAD_BITS - 1;
    localparam int EN_BITS    = 9;
    localparam int LIN_BITS   = 8;
    localparam int TRIM_BITS  = 4;
    localparam int CV_BITS    = 8;
    localparam int ALM_BITS   = 4;

    localparam logic [ADDR_BITS-1:0] A_CTRL   = 6'h00;
    localparam logic [ADDR_BITS-1:0] A_ALARM  = 6'h01;
    localparam logic [ADDR_BITS-1:0] A_MASK   = 6'h02;
    localparam logic [ADDR_BITS-1:0] A_ENABLE = 6'h03;
    localparam logic [ADDR_BITS-1:0] A_LIN    = 6'h04;
    localparam logic [ADDR_BITS-1:0] A_LOPATH = 6'h05;
    localparam logic [ADDR_BITS-1:0] A_CVCTL  = 6'h06;
    localparam logic [ADDR_BITS-1:0] A_CVOUT  = 6'h0C;

    localparam logic [7:0] IDENT_CODE = 8'h0A;

    typedef enum logic [1:0] {FE_IDLE, FE_HEAD, FE_BODY, FE_OVER} fe_state_t;
    typedef enum logic [1:0] {CV_OFF, CV_BUSY, CV_READY} cv_state_t;
endpackage

// File: rtl/cfgspi_shifter.sv
module cfgspi_shifter
    import cfgspi_pkg::*;
#(
    parameter int FRAME_W = FRAME_BITS,
    parameter int HEAD_W  = HEAD_BITS,
    parameter int WORD_W  = WORD_BITS,
    localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               cs_n_i,
    input  logic               mosi_i,
    input  logic [WORD_W-1:0]  rd_word_i,
    output logic               miso_o,
    output logic               head_v_o,
    output logic [HEAD_W-2:0]  head_addr_o,
    output logic               fin_o,
    output logic               fin_ok_o,
    output logic               fin_few_o,
    output logic               fin_many_o,
    output logic [FRAME_W-1:0] fin_word_o
);
    logic [2:0] sclk_sy;
    logic [2:0] cs_sy;
    logic [1:0] mosi_sy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sy <= '0;
            cs_sy   <= '1;
            mosi_sy <= '0;
        end else begin
            sclk_sy <= {sclk_sy[1:0], sclk_i};
            cs_sy   <= {cs_sy[1:0], cs_n_i};
            mosi_sy <= {mosi_sy[0], mosi_i};
        end
    end

    logic rise, fall, cs_go, cs_end, bit_in;
    assign rise   = sclk_sy[1] & ~sclk_sy[2];
    assign fall   = ~sclk_sy[1] & sclk_sy[2];
    assign cs_go  = ~cs_sy[1] & cs_sy[2];
    assign cs_end = cs_sy[1] & ~cs_sy[2];
    assign bit_in = mosi_sy[1];

    fe_state_t          state, state_nxt;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] sh;
    logic [WORD_W-1:0]  tx;
    logic               miso_r;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            FE_IDLE: if (cs_go) state_nxt = FE_HEAD;
            FE_HEAD: begin
                if (cs_end)
                    state_nxt = FE_IDLE;
                else if (rise && cnt == CNT_W'(HEAD_W - 1))
                    state_nxt = FE_BODY;
            end
            FE_BODY: begin
                if (cs_end)
                    state_nxt = FE_IDLE;
                else if (rise && cnt == CNT_W'(FRAME_W))
                    state_nxt = FE_OVER;
            end
            FE_OVER: if (cs_end) state_nxt = FE_IDLE;
            default: state_nxt = FE_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FE_IDLE;
        else        state <= state_nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            sh         <= '0;
            tx         <= '0;
            miso_r     <= 1'b0;
            head_v_o   <= 1'b0;
            fin_o      <= 1'b0;
            fin_ok_o   <= 1'b0;
            fin_few_o  <= 1'b0;
            fin_many_o <= 1'b0;
        end else begin
            head_v_o   <= (state == FE_HEAD) && (state_nxt == FE_BODY);
            fin_o      <= (state != FE_IDLE) && cs_end;
            fin_ok_o   <= (state == FE_BODY) && (cnt == CNT_W'(FRAME_W)) && cs_end;
            fin_few_o  <= cs_end && ((state == FE_HEAD) ||
                          ((state == FE_BODY) && (cnt < CNT_W'(FRAME_W))));
            fin_many_o <= cs_end && (state == FE_OVER);
            if (state == FE_IDLE && cs_go) begin
                cnt    <= '0;
                tx     <= '0;
                miso_r <= 1'b0;
            end else if (cs_end) begin
                miso_r <= 1'b0;
            end else begin
                if (rise && (state == FE_HEAD ||
                    (state == FE_BODY && cnt != CNT_W'(FRAME_W)))) begin
                    cnt <= cnt + 1'b1;
                    sh  <= {sh[FRAME_W-2:0], bit_in};
                end
                if (head_v_o)
                    tx <= sh[HEAD_W-1] ? rd_word_i : '0;
                if (fall && state == FE_BODY) begin
                    miso_r <= tx[WORD_W-1];
                    tx     <= {tx[WORD_W-2:0], 1'b0};
                end else if (fall && state == FE_OVER) begin
                    miso_r <= 1'b0;
                end
            end
        end
    end

    assign head_addr_o = sh[HEAD_W-2:0];
    assign fin_word_o  = sh;
    assign miso_o      = miso_r;

    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FE_IDLE) |-> !miso_o); // R2
    AST_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o); // R7
    AST_FIN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> ($countones({fin_ok_o, fin_few_o, fin_many_o}) == 1)); // R8
endmodule

// File: rtl/cfgspi_conv.sv
module cfgspi_conv
    import cfgspi_pkg::*;
#(
    parameter int LAT   = 16,
    parameter int VAL_W = CV_BITS,
    localparam int LC_W = $clog2(LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [VAL_W-1:0] sample_i,
    output logic             ready_o,
    output logic [VAL_W-1:0] value_o
);
    cv_state_t       state, state_nxt;
    logic [LC_W-1:0] lc;

    always_comb begin
        state_nxt = state;
        unique case (state)
            CV_OFF:   if (go_i) state_nxt = CV_BUSY;
            CV_BUSY: begin
                if (!go_i)
                    state_nxt = CV_OFF;
                else if (lc == LC_W'(LAT - 1))
                    state_nxt = CV_READY;
            end
            CV_READY: if (!go_i) state_nxt = CV_OFF;
            default:  state_nxt = CV_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CV_OFF;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lc      <= '0;
            value_o <= '0;
        end else begin
            if (state == CV_BUSY) lc <= lc + 1'b1;
            else                  lc <= '0;
            if (state == CV_BUSY && state_nxt == CV_READY)
                value_o <= sample_i;
        end
    end

    assign ready_o = (state == CV_READY);

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> !ready_o); // R6
    AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CV_BUSY) |=> $stable(value_o)); // R6
endmodule

// File: rtl/cfgspi_regs.sv
module cfgspi_regs
    import cfgspi_pkg::*;
#(
    parameter logic [3:0] REV_CODE = 4'h1,
    parameter int FRAME_W = FRAME_BITS,
    parameter int WORD_W  = WORD_BITS,
    parameter int ADDR_W  = ADDR_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fin_i,
    input  logic                 fin_ok_i,
    input  logic                 fin_few_i,
    input  logic                 fin_many_i,
    input  logic [FRAME_W-1:0]   fin_word_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    input  logic                 cv_ready_i,
    input  logic [CV_BITS-1:0]   cv_value_i,
    output logic [WORD_W-1:0]    rd_word_o,
    output logic [EN_BITS-1:0]   en_o,
    output logic [LIN_BITS-1:0]  lin_o,
    output logic                 sb_o,
    output logic [TRIM_BITS-1:0] qtrim_o,
    output logic [TRIM_BITS-1:0] itrim_o,
    output logic                 det_o,
    output logic                 cv_go_o
);
    function automatic logic known(input logic [ADDR_W-1:0] a);
        case (a)
            A_CTRL, A_ALARM, A_MASK, A_ENABLE, A_LIN, A_LOPATH, A_CVCTL, A_CVOUT:
                known = 1'b1;
            default: known = 1'b0;
        endcase
    endfunction

    logic                 par_en, soft_q;
    logic [ALM_BITS-1:0]  alarm_q, mask_q;
    logic [3:0]           cvctl_q;

    logic               f_rd;
    logic [ADDR_W-1:0]  f_addr;
    logic [WORD_W-1:0]  f_data;
    logic               par_ok, wr_hit, soft_hit, alm_clr;
    logic [ALM_BITS-1:0] alm_set;

    assign f_rd   = fin_word_i[FRAME_W-1];
    assign f_addr = fin_word_i[FRAME_W-2 -: ADDR_W];
    assign f_data = fin_word_i[WORD_W:1];
    assign par_ok = !par_en || (^fin_word_i);

    assign wr_hit   = fin_i && fin_ok_i && !f_rd && par_ok && known(f_addr) &&
                      (f_addr != A_ALARM) && (f_addr != A_CVOUT);
    assign soft_hit = wr_hit && (f_addr == A_CTRL) && f_data[14];
    assign alm_clr  = fin_i && fin_ok_i && f_rd && (f_addr == A_ALARM);
    assign alm_set  = {fin_i && fin_ok_i && !par_ok,
                       fin_i && fin_few_i,
                       fin_i && fin_many_i,
                       fin_i && fin_ok_i && !known(f_addr)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_en  <= 1'b0;
            soft_q  <= 1'b0;
            alarm_q <= '0;
            mask_q  <= '0;
            en_o    <= '0;
            lin_o   <= '0;
            sb_o    <= 1'b0;
            qtrim_o <= '0;
            itrim_o <= '0;
            cvctl_q <= '0;
        end else begin
            alarm_q <= (alm_clr ? '0 : alarm_q) | alm_set;
            if (soft_hit) begin
                par_en  <= 1'b0;
                soft_q  <= 1'b1;
                mask_q  <= '0;
                en_o    <= '0;
                lin_o   <= '0;
                sb_o    <= 1'b0;
                qtrim_o <= '0;
                itrim_o <= '0;
                cvctl_q <= '0;
            end else if (wr_hit) begin
                case (f_addr)
                    A_CTRL: begin
                        par_en <= f_data[15];
                        soft_q <= 1'b0;
                    end
                    A_MASK:   mask_q  <= f_data[15 -: ALM_BITS];
                    A_ENABLE: en_o    <= f_data[EN_BITS-1:0];
                    A_LIN:    lin_o   <= f_data[LIN_BITS-1:0];
                    A_LOPATH: begin
                        sb_o    <= f_data[10];
                        qtrim_o <= f_data[7:4];
                        itrim_o <= f_data[3:0];
                    end
                    A_CVCTL:  cvctl_q <= f_data[3:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_word_o = '0;
        case (rd_addr_i)
            A_CTRL:   rd_word_o = {par_en, soft_q, 2'b00, IDENT_CODE, REV_CODE};
            A_ALARM:  rd_word_o = {alarm_q, 12'h000};
            A_MASK:   rd_word_o = {mask_q, 12'h000};
            A_ENABLE: rd_word_o = {{(WORD_W-EN_BITS){1'b0}}, en_o};
            A_LIN:    rd_word_o = {{(WORD_W-LIN_BITS){1'b0}}, lin_o};
            A_LOPATH: rd_word_o = {5'b0, sb_o, 2'b00, qtrim_o, itrim_o};
            A_CVCTL:  rd_word_o = {12'h000, cvctl_q};
            A_CVOUT:  rd_word_o = {7'b0, cv_ready_i, cv_value_i};
            default:  rd_word_o = '0;
        endcase
    end

    assign det_o   = cvctl_q[3];
    assign cv_go_o = &cvctl_q[2:0];

    AST_BADCOUNT_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_i && !fin_ok_i) |=> ($stable(en_o) && $stable(lin_o) && $stable(par_en))); // R7
    AST_PARITY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_i && fin_ok_i && !par_ok) |=> ($stable(lin_o) && $stable(en_o) && alarm_q[3])); // R10
    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !alm_clr |=> ((alarm_q & $past(alarm_q)) == $past(alarm_q))); // R11
    AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_hit |=> (en_o == '0 && lin_o == '0 && !par_en && soft_q)); // R12
endmodule

// File: rtl/cfgspi_slave.sv
module cfgspi_slave
    import cfgspi_pkg::*;
#(
    parameter int         ADC_LAT  = 16,
    parameter logic [3:0] REV_CODE = 4'h1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_sclk,
    input  logic                 spi_cs_n,
    input  logic                 spi_mosi,
    output logic                 spi_miso,
    input  logic [CV_BITS-1:0]   adc_sample,
    output logic [EN_BITS-1:0]   en_ctl,
    output logic [LIN_BITS-1:0]  lin_code,
    output logic                 lo_sb_sel,
    output logic [TRIM_BITS-1:0] i_trim,
    output logic [TRIM_BITS-1:0] q_trim,
    output logic                 det_out_sel
);
    logic [WORD_BITS-1:0]  rd_word;
    logic                  head_v;
    logic [ADDR_BITS-1:0]  head_addr;
    logic                  fin, fin_ok, fin_few, fin_many;
    logic [FRAME_BITS-1:0] fin_word;
    logic                  cv_go, cv_ready;
    logic [CV_BITS-1:0]    cv_value;

    cfgspi_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (spi_sclk),
        .cs_n_i      (spi_cs_n),
        .mosi_i      (spi_mosi),
        .rd_word_i   (rd_word),
        .miso_o      (spi_miso),
        .head_v_o    (head_v),
        .head_addr_o (head_addr),
        .fin_o       (fin),
        .fin_ok_o    (fin_ok),
        .fin_few_o   (fin_few),
        .fin_many_o  (fin_many),
        .fin_word_o  (fin_word)
    );

    cfgspi_regs #(.REV_CODE(REV_CODE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .fin_i      (fin),
        .fin_ok_i   (fin_ok),
        .fin_few_i  (fin_few),
        .fin_many_i (fin_many),
        .fin_word_i (fin_word),
        .rd_addr_i  (head_addr),
        .cv_ready_i (cv_ready),
        .cv_value_i (cv_value),
        .rd_word_o  (rd_word),
        .en_o       (en_ctl),
        .lin_o      (lin_code),
        .sb_o       (lo_sb_sel),
        .qtrim_o    (q_trim),
        .itrim_o    (i_trim),
        .det_o      (det_out_sel),
        .cv_go_o    (cv_go)
    );

    cfgspi_conv #(.LAT(ADC_LAT)) u_conv (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (cv_go),
        .sample_i (adc_sample),
        .ready_o  (cv_ready),
        .value_o  (cv_value)
    );

    AST_HEAD_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        head_v |-> !fin); // R1
endmodule

// File: tb/cfgspi_slave_tb.sv
module cfgspi_slave_tb;
    localparam int HP = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic [7:0] adc_sample = 8'h00;
    logic       miso, lo_sb_sel, det_out_sel;
    logic [8:0] en_ctl;
    logic [7:0] lin_code;
    logic [3:0] i_trim, q_trim;

    cfgspi_slave #(.ADC_LAT(1000), .REV_CODE(4'h1)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .adc_sample(adc_sample),
        .en_ctl(en_ctl), .lin_code(lin_code), .lo_sb_sel(lo_sb_sel),
        .i_trim(i_trim), .q_trim(q_trim), .det_out_sel(det_out_sel)
    );

    typedef struct {
        bit          chk;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int    n_cmp = 0, n_bad = 0;
    bit    par_mode = 1'b0, reported = 1'b0;

    task automatic tally(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // driver: pushes expectation, then shifts the frame out
    task automatic xfer(input bit rd, input logic [5:0] a, input logic [15:0] d,
                        input int nclk, input bit badp, input bit chk,
                        input logic [15:0] exp, input string tag);
        logic [23:0] w;
        logic        p;
        item_t       it;
        p = par_mode ? ((~^{rd, a, d}) ^ badp) : 1'b0;
        w = {rd, a, d, p};
        it.chk = chk; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk) cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            mosi = (i < 24) ? w[23-i] : 1'b0;
            repeat (HP) @(negedge clk);
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        xfer(1'b0, a, d, 24, 1'b0, 1'b0, 16'h0, "wr");
    endtask

    task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
        xfer(1'b1, a, 16'h0, 24, 1'b0, 1'b1, exp, tag);
    endtask

    // monitor: assembles each frame from the data output and compares
    initial begin
        logic [23:0] rx;
        int          n;
        item_t       it;
        forever begin
            @(negedge cs_n);
            rx = '0;
            n  = 0;
            forever begin
                @(posedge sclk or posedge cs_n);
                if (cs_n) break;
                rx = {rx[22:0], miso};
                n++;
            end
            if (sbq.size() == 0) begin
                tally(1'b0, "R1 unexpected frame", 16'(n), 16'h0);
            end else begin
                it = sbq.pop_front();
                if (it.chk)
                    tally((rx[16:1] == it.exp) && (n == 24) && !rx[0], it.tag, rx[16:1], it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        tally(1'b0, "R1 watchdog expired", 16'h0, 16'h1);
        report();
    end

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state
        tally(en_ctl == 9'h000, "R4 reset enables", 16'(en_ctl), 16'h0);
        tally(miso == 1'b0, "R2 idle output low", 16'(miso), 16'h0);
        rd(6'h00, 16'h00A1, "R3 identity and revision");

        // enable word with several patterns
        wr(6'h03, 16'h0155);
        tally(en_ctl == 9'h155, "R4 enable output", 16'(en_ctl), 16'h0155);
        rd(6'h03, 16'h0155, "R1 readback 0155");
        wr(6'h03, 16'h00AA);
        rd(6'h03, 16'h00AA, "R1 readback 00AA");
        wr(6'h03, 16'hFFFF);
        rd(6'h03, 16'h01FF, "R4 upper bits dropped");
        wr(6'h03, 16'h0000);
        tally(en_ctl == 9'h000, "R4 write zero powers down", 16'(en_ctl), 16'h0);

        // LO path and linearizer
        wr(6'h05, 16'hFFFF);
        rd(6'h05, 16'h04FF, "R5 lo path all ones");
        tally({lo_sb_sel, q_trim, i_trim} == 9'h1FF, "R5 lo outputs ones",
              16'({lo_sb_sel, q_trim, i_trim}), 16'h01FF);
        wr(6'h05, 16'h0093);
        rd(6'h05, 16'h0093, "R5 lo path 0093");
        tally({lo_sb_sel, q_trim, i_trim} == 9'h093, "R5 trims split",
              16'({lo_sb_sel, q_trim, i_trim}), 16'h0093);
        wr(6'h04, 16'h12C3);
        rd(6'h04, 16'h00C3, "R5 linearizer");
        tally(lin_code == 8'hC3, "R5 lin output", 16'(lin_code), 16'h00C3);
        tally(miso == 1'b0, "R2 output low after frame", 16'(miso), 16'h0);

        // read-only writes ignored
        wr(6'h0C, 16'hFFFF);
        rd(6'h0C, 16'h0000, "R13 converter output not writable");
        wr(6'h01, 16'hFFFF);
        rd(6'h01, 16'h0000, "R13 alarm not writable, no alarm");

        // unknown addresses
        wr(6'h10, 16'h1234);
        wr(6'h07, 16'h0011);
        tally(lin_code == 8'hC3, "R9 unknown write no effect", 16'(lin_code), 16'h00C3);
        rd(6'h01, 16'h1000, "R9 address alarm");
        rd(6'h01, 16'h0000, "R11 alarm cleared by read");
        rd(6'h3F, 16'h0000, "R9 unknown read returns zero");
        rd(6'h01, 16'h1000, "R9 address alarm from read");

        // clock count faults
        xfer(1'b0, 6'h04, 16'h0011, 20, 1'b0, 1'b0, 16'h0, "short");
        tally(lin_code == 8'hC3, "R7 short frame discarded", 16'(lin_code), 16'h00C3);
        rd(6'h01, 16'h4000, "R7 too-few alarm");
        xfer(1'b0, 6'h04, 16'h0022, 28, 1'b0, 1'b0, 16'h0, "long");
        tally(lin_code == 8'hC3, "R8 long frame discarded", 16'(lin_code), 16'h00C3);
        rd(6'h01, 16'h2000, "R8 too-many alarm");
        xfer(1'b0, 6'h03, 16'h0001, 0, 1'b0, 1'b0, 16'h0, "empty");
        xfer(1'b0, 6'h03, 16'h0001, 30, 1'b0, 1'b0, 16'h0, "long2");
        tally(en_ctl == 9'h000, "R7 empty frame discarded", 16'(en_ctl), 16'h0);
        rd(6'h01, 16'h6000, "R11 alarms accumulate");
        rd(6'h01, 16'h0000, "R11 accumulated cleared");

        // converter model
        adc_sample = 8'h5C;
        wr(6'h06, 16'h000F);
        rd(6'h0C, 16'h0000, "R6 not ready before latency");
        tally(det_out_sel == 1'b1, "R6 detector select", 16'(det_out_sel), 16'h1);
        repeat (1100) @(negedge clk);
        rd(6'h0C, 16'h015C, "R6 ready with value");
        adc_sample = 8'h33;
        rd(6'h0C, 16'h015C, "R6 value held");
        wr(6'h06, 16'h000B);
        rd(6'h0C, 16'h005C, "R6 ready clears, value kept");

        // parity
        wr(6'h00, 16'h8000);
        par_mode = 1'b1;
        rd(6'h00, 16'h80A1, "R10 parity enabled");
        wr(6'h04, 16'h005A);
        rd(6'h04, 16'h005A, "R10 good parity write");
        xfer(1'b0, 6'h04, 16'h0033, 24, 1'b1, 1'b0, 16'h0, "badpar");
        tally(lin_code == 8'h5A, "R10 bad parity write blocked", 16'(lin_code), 16'h005A);
        rd(6'h01, 16'h8000, "R10 parity alarm");
        xfer(1'b1, 6'h04, 16'h0000, 24, 1'b1, 1'b1, 16'h005A, "R10 bad parity read returns data");
        rd(6'h01, 16'h8000, "R10 parity alarm on read");

        // soft reset
        wr(6'h03, 16'h01FF);
        wr(6'h00, 16'h4000);
        par_mode = 1'b0;
        tally(en_ctl == 9'h000, "R12 soft reset enables", 16'(en_ctl), 16'h0);
        tally(lin_code == 8'h00, "R12 soft reset linearizer", 16'(lin_code), 16'h0);
        rd(6'h00, 16'h40A1, "R12 soft bit holds, parity off");
        rd(6'h06, 16'h0000, "R12 converter control cleared");
        rd(6'h0C, 16'h005C, "R12 converter value kept");
        wr(6'h00, 16'h0000);
        rd(6'h00, 16'h00A1, "R12 soft bit cleared");

        wait (sbq.size() == 0);
        repeat (20) @(negedge clk);
        report();
    end
endmodule